// File: doc/BRIEF.md
# Colour Palette Index/Data Port

This block holds the colour palette store for a tile-based display and gives the CPU two indexed windows into it: a background window and an object window. Each window has an index register, which picks one byte of the palette, and a data register, which shows that byte and writes through to it. A CPU that sets the auto-increment flag in the index can load a whole palette by writing the data register repeatedly, because the index steps forward after every data write.

The store holds 64 colour entries of 16 bits. The background window reaches entries 0 to 31, which is eight palettes of four colours. The object window reaches entries 32 to 63. The display pipeline has its own read port. It takes an entry number and returns that entry's 15-bit colour in the same cycle.

A small decoder turns each bus write into one named access kind: ACC_NONE, ACC_BG_IDX, ACC_BG_DAT, ACC_OBJ_IDX or ACC_OBJ_DAT. The window logic acts on that access kind. There are no other states. Each index/data pair changes only on a write to its own window.

Top module: `cpal_access`

## Requirements
- R1: After reset, both index registers hold index 0 with auto-increment off, both index reads return 0x40, and every palette byte and both data registers are 0x00.
- R2: The register addresses are 0 for the background index, 1 for the background data, 2 for the object index and 3 for the object data. Reading an index register returns {auto-increment in bit 7, a constant 1 in bit 6, the index in bits 5:0}. Bit 6 of a written value is ignored.
- R3: After an index write, the data register of that window shows the palette byte the new index selects, starting in the next cycle. Index bits 5:1 give the entry within the window, and bit 0 gives the byte: 0 selects colour bits 7:0 and 1 selects colour bits 15:8.
- R4: A data write stores the byte at the position the index selects. With auto-increment off, the data register then reads back the written byte.
- R5: A data write with auto-increment on advances the index by one, wrapping from 63 to 0 inside the same window. The data register then shows the byte at the new index.
- R6: A data write with auto-increment off leaves the index unchanged.
- R7: Background index i addresses entry i[5:1]. Object index i addresses entry 32 + i[5:1]. The two windows never reach each other's entries.
- R8: A write through one window changes neither the index nor the data register of the other window.
- R9: disp_color gives bits 14:0 of the entry chosen by disp_entry, in the same cycle. Bit 15 of the entry never appears on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 2 | CPU register select |
| bus_wr | input | 1 | CPU write strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | CPU read data for bus_addr (combinational) |
| disp_entry | input | 6 | Display colour entry number |
| disp_color | output | 15 | 15-bit colour of the selected entry |

## Verification
The bench goes after the wrap of an auto-incrementing index from 63 to 0. A design that carried into the window bit would leak object writes into background entries, or background writes into object entries. It checks a data write with auto-increment off. A design that reloaded the data register from the store before the write landed would show the old byte. It checks index writes with bit 6 set, which would expose a design that stored that bit. It also writes bit 15 of entries, which a display port that did not mask the top bit would show. Random writes to all four registers are checked against a model of both windows and the store after every operation.

// File: rtl/cpal_pkg.sv
package cpal_pkg;
    localparam int NPORT  = 2;                 // background and object windows
    localparam int IDX_W  = 6;                 // byte index within a window
    localparam int BYTE_W = 8;
    localparam int PORT_W = $clog2(NPORT);
    localparam int BADR_W = PORT_W + IDX_W;    // byte address in the store
    localparam int ENT_W  = BADR_W - 1;        // colour entry number
    localparam int COL_W  = 15;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_BG_IDX,
        ACC_BG_DAT,
        ACC_OBJ_IDX,
        ACC_OBJ_DAT
    } acc_e;
endpackage

// File: rtl/cpal_decode.sv
module cpal_decode
    import cpal_pkg::*;
(
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    output logic [NPORT-1:0] idx_wr,
    output logic [NPORT-1:0] dat_wr
);
    acc_e acc;

    always_comb begin
        if (!bus_wr) begin
            acc = ACC_NONE;
        end else begin
            unique case (bus_addr)
                2'd0: acc = ACC_BG_IDX;
                2'd1: acc = ACC_BG_DAT;
                2'd2: acc = ACC_OBJ_IDX;
                2'd3: acc = ACC_OBJ_DAT;
            endcase
        end
    end

    always_comb begin
        idx_wr = '0;
        dat_wr = '0;
        unique case (acc)
            ACC_NONE:    ;
            ACC_BG_IDX:  idx_wr[0] = 1'b1;
            ACC_BG_DAT:  dat_wr[0] = 1'b1;
            ACC_OBJ_IDX: idx_wr[1] = 1'b1;
            ACC_OBJ_DAT: dat_wr[1] = 1'b1;
            default:     ;
        endcase
    end
endmodule

// File: rtl/cpal_port.sv
module cpal_port
    import cpal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              dat_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] look_byte,
    output logic [IDX_W-1:0]  look_idx,
    output logic [IDX_W-1:0]  idx_q,
    output logic              inc_q,
    output logic [BYTE_W-1:0] data_q,
    output logic              st_we,
    output logic [IDX_W-1:0]  st_idx
);
    logic [IDX_W-1:0]  idx_d;
    logic              inc_d;
    logic [BYTE_W-1:0] data_d;

    // Next index and next data byte. The next index is also the address
    // that the store looks up for the data reload.
    always_comb begin
        idx_d  = idx_q;
        inc_d  = inc_q;
        data_d = data_q;
        if (idx_wr) begin
            idx_d  = wdata[IDX_W-1:0];
            inc_d  = wdata[BYTE_W-1];
            data_d = look_byte;
        end else if (dat_wr) begin
            if (inc_q) begin
                idx_d  = idx_q + IDX_W'(1);
                data_d = look_byte;
            end else begin
                data_d = wdata;
            end
        end
    end

    assign look_idx = idx_d;
    assign st_we    = dat_wr;
    assign st_idx   = idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            inc_q  <= 1'b0;
            data_q <= '0;
        end else begin
            idx_q  <= idx_d;
            inc_q  <= inc_d;
            data_q <= data_d;
        end
    end
endmodule

// File: rtl/cpal_store.sv
module cpal_store
    import cpal_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [BADR_W-1:0]            waddr,
    input  logic [BYTE_W-1:0]            wdata,
    input  logic [NPORT-1:0][BADR_W-1:0] look_addr,
    output logic [NPORT-1:0][BYTE_W-1:0] look_byte,
    input  logic [ENT_W-1:0]             disp_entry,
    output logic [COL_W-1:0]             disp_color
);
    localparam int NBYTE = 2 ** BADR_W;

    logic [BYTE_W-1:0] mem [NBYTE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTE; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_look
        assign look_byte[p] = mem[look_addr[p]];
    end

    logic [BYTE_W-1:0] lo_b, hi_b;
    assign lo_b = mem[{disp_entry, 1'b0}];
    assign hi_b = mem[{disp_entry, 1'b1}];
    assign disp_color = {hi_b[COL_W-BYTE_W-1:0], lo_b};
endmodule

// File: rtl/cpal_access.sv
module cpal_access
    import cpal_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [5:0]  disp_entry,
    output logic [14:0] disp_color
);
    logic [NPORT-1:0]             idx_wr, dat_wr, inc_q, st_we;
    logic [NPORT-1:0][IDX_W-1:0]  idx_q, look_idx, st_idx;
    logic [NPORT-1:0][BYTE_W-1:0] data_q, look_byte;
    logic [NPORT-1:0][BADR_W-1:0] look_addr;
    logic                         we;
    logic [BADR_W-1:0]            waddr;

    cpal_decode u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .idx_wr   (idx_wr),
        .dat_wr   (dat_wr)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        cpal_port u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .idx_wr    (idx_wr[p]),
            .dat_wr    (dat_wr[p]),
            .wdata     (bus_wdata),
            .look_byte (look_byte[p]),
            .look_idx  (look_idx[p]),
            .idx_q     (idx_q[p]),
            .inc_q     (inc_q[p]),
            .data_q    (data_q[p]),
            .st_we     (st_we[p]),
            .st_idx    (st_idx[p])
        );
        assign look_addr[p] = {PORT_W'(p), look_idx[p]};
    end

    // At most one window writes per cycle.
    always_comb begin
        we    = 1'b0;
        waddr = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (st_we[p]) begin
                we    = 1'b1;
                waddr = {PORT_W'(p), st_idx[p]};
            end
        end
    end

    cpal_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (we),
        .waddr      (waddr),
        .wdata      (bus_wdata),
        .look_addr  (look_addr),
        .look_byte  (look_byte),
        .disp_entry (disp_entry),
        .disp_color (disp_color)
    );

    always_comb begin
        unique case (bus_addr[0])
            1'b0: bus_rdata = {inc_q[bus_addr[1]], 1'b1, idx_q[bus_addr[1]]};
            1'b1: bus_rdata = data_q[bus_addr[1]];
        endcase
    end
endmodule

// File: rtl/cpal_access_chk.sv
module cpal_access_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  bus_addr,
    input logic        bus_wr,
    input logic [7:0]  bus_wdata,
    input logic [1:0]  inc_q,
    input logic [11:0] idx_flat,
    input logic [15:0] dat_flat
);
    logic [5:0] bg_idx, ob_idx;
    logic [7:0] bg_dat, ob_dat;
    assign bg_idx = idx_flat[5:0];
    assign ob_idx = idx_flat[11:6];
    assign bg_dat = dat_flat[7:0];
    assign ob_dat = dat_flat[15:8];

    assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> (bg_idx == $past(bus_wdata[5:0]) && inc_q[0] == $past(bus_wdata[7])));

    assert_hold_no_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && !inc_q[0]) |=> $stable(bg_idx));

    assert_step_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3 && inc_q[1]) |=> (ob_idx == $past(ob_idx) + 6'd1));

    assert_echo_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && !inc_q[0]) |=> (bg_dat == $past(bus_wdata)));

    assert_obj_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[1]) |=> ($stable(bg_idx) && $stable(bg_dat)));

    assert_bg_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr[1]) |=> ($stable(ob_idx) && $stable(ob_dat)));
endmodule

bind cpal_access cpal_access_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .inc_q     (inc_q),
    .idx_flat  (idx_q),
    .dat_flat  (data_q)
);

// File: tb/cpal_access_tb.sv
module cpal_access_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [5:0]  disp_entry = '0;
    logic [14:0] disp_color;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model
    logic [7:0] m_mem [128];
    logic [5:0] m_idx [2];
    logic       m_inc [2];
    logic [7:0] m_dat [2];

    always #4 clk = ~clk;

    cpal_access dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .disp_entry(disp_entry), .disp_color(disp_color)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [14:0] exp_color(input logic [5:0] e);
        return {m_mem[{e, 1'b1}][6:0], m_mem[{e, 1'b0}]};
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        if (a[0]) return m_dat[a[1]];
        return {m_inc[a[1]], 1'b1, m_idx[a[1]]};
    endfunction

    task automatic model_write(input logic [1:0] a, input logic [7:0] d);
        int p = int'(a[1]);
        if (!a[0]) begin
            m_idx[p] = d[5:0];
            m_inc[p] = d[7];
        end else begin
            m_mem[{a[1], m_idx[p]}] = d;
            if (m_inc[p]) m_idx[p] = m_idx[p] + 6'd1;
        end
        m_dat[p] = m_mem[{a[1], m_idx[p]}];
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic read_chk(input string req, input logic [1:0] a);
        bus_addr = a;
        #1;
        chk(req, {8'h00, bus_rdata}, {8'h00, exp_read(a)});
    endtask

    task automatic disp_chk(input string req, input logic [5:0] e);
        disp_entry = e;
        #1;
        chk(req, {1'b0, disp_color}, {1'b0, exp_color(e)});
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
        for (int p = 0; p < 2; p++) begin
            m_idx[p] = '0; m_inc[p] = 1'b0; m_dat[p] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) read_chk("R1", 2'(a));
        disp_chk("R1", 6'd0);
        disp_chk("R1", 6'd63);

        // R2: bit 6 of the index write is ignored
        bus_write(2'd0, 8'h45);
        read_chk("R2", 2'd0);
        chk("R2", {8'h00, bus_rdata}, 16'h0045);

        // R4: write without increment echoes, R6 index held
        bus_write(2'd1, 8'hA7);
        read_chk("R4", 2'd1);
        read_chk("R6", 2'd0);

        // R3: reload after index write, low/high byte selection
        bus_write(2'd0, 8'h04);
        bus_write(2'd1, 8'h3C);
        bus_write(2'd0, 8'h05);
        bus_write(2'd1, 8'h81);
        bus_write(2'd0, 8'h04);
        read_chk("R3", 2'd1);
        disp_chk("R9", 6'd2);       // entry 2: bit 15 written as 1
        chk("R9", {1'b0, disp_color}, 16'h013C);

        // R5/R7: object window wraps 63 -> 0 inside its own region
        bus_write(2'd2, 8'hBF);     // inc on, index 63
        bus_write(2'd3, 8'hEE);
        read_chk("R5", 2'd2);
        chk("R5", {8'h00, bus_rdata}, 16'h00C0);
        read_chk("R5", 2'd3);
        bus_write(2'd3, 8'h5A);     // lands on entry 32 low byte
        disp_chk("R7", 6'd32);
        disp_chk("R7", 6'd63);
        disp_chk("R7", 6'd0);
        read_chk("R8", 2'd0);
        read_chk("R8", 2'd1);

        // background auto-increment wrap
        bus_write(2'd0, 8'hFF);
        bus_write(2'd1, 8'h11);
        read_chk("R5", 2'd0);
        read_chk("R5", 2'd1);

        // random traffic checked against model
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] a;
            logic [7:0] d;
            a = 2'($urandom_range(0, 3));
            d = 8'($urandom);
            if (a[0] == 1'b0 && ($urandom_range(0, 3) == 0)) d[5:0] = 6'h3F;
            bus_write(a, d);
            read_chk(a[0] ? "R4" : "R3", a);
            read_chk("R8", {~a[1], 1'b0});
            read_chk("R8", {~a[1], 1'b1});
            disp_chk("R9", 6'($urandom_range(0, 63)));
        end

        // full sweep of the display port
        for (int e = 0; e < 64; e++) disp_chk("R7", 6'(e));

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule